// File: doc/BRIEF.md
# IRQ Entry and Exception-Return Sequencer

This block is the interrupt control slice of a small processor core. It holds the status word, the IRQ saved-status register and two banks of stack pointer and link register. When the interrupt request line is high at an instruction boundary and the status word does not mask it, the block performs the whole entry in one clock edge. It saves the status word and enters IRQ mode, which switches the register banks. It sets the IRQ-disable bit, forces the wide instruction state, loads the IRQ link register with a return value and redirects fetch to the fixed IRQ vector.

A single return strobe undoes the entry. The saved status goes back into the status word, which brings back the earlier mode and bank and the earlier instruction state. Fetch is redirected to the IRQ link value minus 4. The rest of the core writes the status word, the stack pointer and the link register through simple write strobes. These writes land in whichever bank the current mode selects. Instruction decode, arithmetic and memory access sit outside the block.

Top module: `irq_seq`

## Requirements
- R1: Reset loads the status word with `RST_STATUS` (default 0x0000_0010: mode 5'b10000, IRQ-disable clear, wide state). It clears the saved status, both register banks and the fetch redirect, and leaves no saved state.
- R2: An accepted IRQ sets status bits [4:0] to 5'b10010 (IRQ mode). The stack and link selects then move to bank 1, and the bank-0 stack and link values are kept unchanged.
- R3: An accepted IRQ copies the pre-entry status word into the saved-status register.
- R4: An accepted IRQ sets status bit 7 (IRQ-disable) and clears status bit 5 (compact-state flag). All other status bits are unchanged.
- R5: An accepted IRQ loads the IRQ link register with `pc_i + 8` when bit 5 was clear and with `pc_i + 6` when it was set. `pc_i` is the address of the instruction just completed, so the value is always 4 beyond the next instruction.
- R6: On the cycle after an accepted IRQ, `fetch_valid_o` is 1 and `fetch_addr_o` is 0x18.
- R7: An IRQ is accepted only when `irq_i` and `boundary_i` are both high and status bit 7 is clear. Otherwise the status, the saved status and fetch are untouched, and this includes nested requests inside a masked handler.
- R8: A return while saved state exists copies the saved status back into the status word. On the next cycle it redirects fetch to the IRQ link value minus 4, and the bank selects follow the restored mode.
- R9: A return with no saved state changes no register and raises no fetch redirect.
- R10: A return with saved state has priority over a simultaneous IRQ. A status write in the same cycle as an entry or a return is dropped.
- R11: Stack and link writes land in the bank that the current mode selects. `ret_addr_o` always shows the IRQ link value minus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 1 | Interrupt request level |
| boundary_i | input | 1 | High when an instruction has just completed |
| ret_i | input | 1 | Exception-return strobe |
| pc_i | input | XLEN | Address of the instruction just completed |
| status_wr_i | input | 1 | Status word write strobe |
| status_wdata_i | input | XLEN | Status word write data |
| sp_wr_i | input | 1 | Stack pointer write strobe (current bank) |
| lr_wr_i | input | 1 | Link register write strobe (current bank) |
| reg_wdata_i | input | XLEN | Data for stack or link write |
| status_o | output | XLEN | Current status word |
| spsr_o | output | XLEN | IRQ saved-status register |
| mode_o | output | MODE_W | Current mode field |
| sp_sel_o | output | BANK_W | Selected stack bank |
| lr_sel_o | output | BANK_W | Selected link bank |
| sp_o | output | XLEN | Stack pointer of the selected bank |
| lr_o | output | XLEN | Link register of the selected bank |
| ret_addr_o | output | XLEN | IRQ link value minus 4 |
| fetch_valid_o | output | 1 | One-cycle fetch redirect pulse |
| fetch_addr_o | output | XLEN | Redirect target |

## Verification
The assertions check the following on every cycle:
- the shape of each entry: mode, mask, state bit, saved copy and vector redirect;
- the exact restoring of the status word and the return target on each return;
- that nothing moves when a request is masked;
- that an empty return changes nothing.

Some behaviours only the bench scenarios can show:
- the banked stack and link values surviving a whole entry and return;
- the return landing on the right instruction for both instruction states across a sweep of addresses;
- return-over-IRQ priority;
- dropped status writes.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_ENTER  = 2'd1,
      SEQ_RETURN = 2'd2
   } seq_op_e;

endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb
   import irq_seq_pkg::*;
(
   input  logic    irq_i,
   input  logic    boundary_i,
   input  logic    ret_i,
   input  logic    saved_i,
   input  logic    masked_i,
   output seq_op_e op_o
);

   always_comb begin
      op_o = SEQ_IDLE;
      if (ret_i && saved_i)
         op_o = SEQ_RETURN;
      else if (irq_i && boundary_i && !masked_i)
         op_o = SEQ_ENTER;
   end

endmodule

// File: rtl/irq_seq_status.sv
module irq_seq_status
   import irq_seq_pkg::*;
#(
   parameter int                 XLEN       = 32,
   parameter int                 MODE_W     = 5,
   parameter logic [MODE_W-1:0]  IRQ_MODE   = 5'b10010,
   parameter int                 IDIS_BIT   = 7,
   parameter int                 CMP_BIT    = 5,
   parameter logic [XLEN-1:0]    RST_STATUS = 32'h0000_0010
)(
   input  logic            clk,
   input  logic            rst_n,
   input  seq_op_e         op_i,
   input  logic            wr_i,
   input  logic [XLEN-1:0] wdata_i,
   output logic [XLEN-1:0] status_o,
   output logic [XLEN-1:0] spsr_o,
   output logic            saved_o
);

   logic [XLEN-1:0] status_q, spsr_q, enter_val;
   logic            saved_q;

   always_comb begin
      enter_val                = status_q;
      enter_val[MODE_W-1:0]    = IRQ_MODE;
      enter_val[IDIS_BIT]      = 1'b1;
      enter_val[CMP_BIT]       = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= RST_STATUS;
         spsr_q   <= '0;
         saved_q  <= 1'b0;
      end else begin
         unique case (op_i)
            SEQ_ENTER: begin
               spsr_q   <= status_q;
               status_q <= enter_val;
               saved_q  <= 1'b1;
            end
            SEQ_RETURN: begin
               status_q <= spsr_q;
               saved_q  <= 1'b0;
            end
            default: begin
               if (wr_i) status_q <= wdata_i;
            end
         endcase
      end
   end

   assign status_o = status_q;
   assign spsr_o   = spsr_q;
   assign saved_o  = saved_q;

   AST_ENTRY_SAVES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == SEQ_ENTER) |=> (spsr_q == $past(status_q)));                 // R3
   AST_ENTRY_STATUS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == SEQ_ENTER) |=> (status_q[MODE_W-1:0] == IRQ_MODE &&
                               status_q[IDIS_BIT] && !status_q[CMP_BIT]));   // R4
   AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == SEQ_RETURN) |=> (status_q == $past(spsr_q) && !saved_q));    // R8

endmodule

// File: rtl/irq_seq_bank.sv
module irq_seq_bank #(
   parameter int XLEN     = 32,
   parameter int NBANK    = 2,
   parameter int IRQ_BANK = 1,
   localparam int BANK_W  = (NBANK > 1) ? $clog2(NBANK) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] sel_i,
   input  logic              sp_wr_i,
   input  logic              lr_wr_i,
   input  logic [XLEN-1:0]   wdata_i,
   input  logic              ld_lr_i,
   input  logic [XLEN-1:0]   ld_lr_data_i,
   output logic [XLEN-1:0]   sp_o,
   output logic [XLEN-1:0]   lr_o,
   output logic [XLEN-1:0]   lr_irq_o
);

   logic [XLEN-1:0] sp_q [NBANK];
   logic [XLEN-1:0] lr_q [NBANK];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam logic [BANK_W-1:0] IDX = BANK_W'(b);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sp_q[b] <= '0;
            lr_q[b] <= '0;
         end else begin
            if (sp_wr_i && sel_i == IDX)
               sp_q[b] <= wdata_i;
            if (ld_lr_i && b == IRQ_BANK)
               lr_q[b] <= ld_lr_data_i;
            else if (lr_wr_i && sel_i == IDX)
               lr_q[b] <= wdata_i;
         end
      end
   end

   assign sp_o     = sp_q[sel_i];
   assign lr_o     = lr_q[sel_i];
   assign lr_irq_o = lr_q[IRQ_BANK];

endmodule

// File: rtl/irq_seq.sv
module irq_seq
   import irq_seq_pkg::*;
#(
   parameter int                 XLEN        = 32,
   parameter int                 MODE_W      = 5,
   parameter logic [MODE_W-1:0]  IRQ_MODE    = 5'b10010,
   parameter int                 IDIS_BIT    = 7,
   parameter int                 CMP_BIT     = 5,
   parameter logic [XLEN-1:0]    VEC_ADDR    = 32'h0000_0018,
   parameter logic [XLEN-1:0]    RST_STATUS  = 32'h0000_0010,
   parameter int                 WIDE_STEP   = 4,
   parameter int                 CMP_STEP    = 2,
   parameter int                 RET_ADJ     = 4,
   parameter bit                 HAS_COMPACT = 1'b1,
   parameter int                 NBANK       = 2,
   localparam int                BANK_W      = (NBANK > 1) ? $clog2(NBANK) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_i,
   input  logic              boundary_i,
   input  logic              ret_i,
   input  logic [XLEN-1:0]   pc_i,
   input  logic              status_wr_i,
   input  logic [XLEN-1:0]   status_wdata_i,
   input  logic              sp_wr_i,
   input  logic              lr_wr_i,
   input  logic [XLEN-1:0]   reg_wdata_i,
   output logic [XLEN-1:0]   status_o,
   output logic [XLEN-1:0]   spsr_o,
   output logic [MODE_W-1:0] mode_o,
   output logic [BANK_W-1:0] sp_sel_o,
   output logic [BANK_W-1:0] lr_sel_o,
   output logic [XLEN-1:0]   sp_o,
   output logic [XLEN-1:0]   lr_o,
   output logic [XLEN-1:0]   ret_addr_o,
   output logic              fetch_valid_o,
   output logic [XLEN-1:0]   fetch_addr_o
);

   localparam int IRQ_BANK = 1;

   if (NBANK < 2) begin : g_chk_bank
      $error("irq_seq: NBANK must be at least 2");
   end
   if (IDIS_BIT >= XLEN || CMP_BIT >= XLEN || MODE_W > XLEN) begin : g_chk_bits
      $error("irq_seq: status field positions exceed XLEN");
   end
   if (IDIS_BIT < MODE_W || CMP_BIT < MODE_W) begin : g_chk_overlap
      $error("irq_seq: flag bits overlap the mode field");
   end

   seq_op_e           op;
   logic [XLEN-1:0]   status_q, spsr_q, lr_irq, link_val;
   logic              saved_q;
   logic [BANK_W-1:0] bank_sel;
   logic              fetch_valid_q;
   logic [XLEN-1:0]   fetch_addr_q;

   irq_seq_arb u_arb (
      .irq_i      (irq_i),
      .boundary_i (boundary_i),
      .ret_i      (ret_i),
      .saved_i    (saved_q),
      .masked_i   (status_q[IDIS_BIT]),
      .op_o       (op)
   );

   irq_seq_status #(
      .XLEN(XLEN), .MODE_W(MODE_W), .IRQ_MODE(IRQ_MODE),
      .IDIS_BIT(IDIS_BIT), .CMP_BIT(CMP_BIT), .RST_STATUS(RST_STATUS)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (op),
      .wr_i     (status_wr_i),
      .wdata_i  (status_wdata_i),
      .status_o (status_q),
      .spsr_o   (spsr_q),
      .saved_o  (saved_q)
   );

   assign bank_sel = (status_q[MODE_W-1:0] == IRQ_MODE) ? BANK_W'(IRQ_BANK) : '0;

   // Return value: address of next instruction plus RET_ADJ.
   if (HAS_COMPACT) begin : g_link_dual
      assign link_val = pc_i + (status_q[CMP_BIT] ? XLEN'(CMP_STEP + RET_ADJ)
                                                  : XLEN'(WIDE_STEP + RET_ADJ));
   end else begin : g_link_wide
      assign link_val = pc_i + XLEN'(WIDE_STEP + RET_ADJ);
   end

   irq_seq_bank #(
      .XLEN(XLEN), .NBANK(NBANK), .IRQ_BANK(IRQ_BANK)
   ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel_i        (bank_sel),
      .sp_wr_i      (sp_wr_i),
      .lr_wr_i      (lr_wr_i),
      .wdata_i      (reg_wdata_i),
      .ld_lr_i      (op == SEQ_ENTER),
      .ld_lr_data_i (link_val),
      .sp_o         (sp_o),
      .lr_o         (lr_o),
      .lr_irq_o     (lr_irq)
   );

   assign ret_addr_o = lr_irq - XLEN'(RET_ADJ);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fetch_valid_q <= 1'b0;
         fetch_addr_q  <= '0;
      end else begin
         fetch_valid_q <= (op != SEQ_IDLE);
         if (op == SEQ_ENTER)
            fetch_addr_q <= VEC_ADDR;
         else if (op == SEQ_RETURN)
            fetch_addr_q <= ret_addr_o;
      end
   end

   assign status_o      = status_q;
   assign spsr_o        = spsr_q;
   assign mode_o        = status_q[MODE_W-1:0];
   assign sp_sel_o      = bank_sel;
   assign lr_sel_o      = bank_sel;
   assign fetch_valid_o = fetch_valid_q;
   assign fetch_addr_o  = fetch_addr_q;

   AST_ENTRY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_i && boundary_i && !status_q[IDIS_BIT] && !(ret_i && saved_q))
      |=> (fetch_valid_o && fetch_addr_o == VEC_ADDR && mode_o == IRQ_MODE)); // R6
   AST_ENTRY_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      (op == SEQ_ENTER) |=> (lr_o == $past(link_val) && sp_sel_o == BANK_W'(IRQ_BANK))); // R5
   AST_MASKED_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[IDIS_BIT] && !(ret_i && saved_q)) |=> $stable(spsr_o));     // R7
   AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && saved_q) |=> (fetch_valid_o && fetch_addr_o == $past(lr_irq) - XLEN'(RET_ADJ))); // R8
   AST_EMPTY_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !saved_q && !irq_i && !status_wr_i)
      |=> ($stable(status_o) && $stable(spsr_o) && !fetch_valid_o));       // R9

endmodule

// File: tb/irq_seq_bench.sv
module irq_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_i = 0, boundary_i = 0, ret_i = 0;
   logic [31:0] pc_i = '0;
   logic        status_wr_i = 0, sp_wr_i = 0, lr_wr_i = 0;
   logic [31:0] status_wdata_i = '0, reg_wdata_i = '0;
   logic [31:0] status_o, spsr_o, sp_o, lr_o, ret_addr_o, fetch_addr_o;
   logic [4:0]  mode_o;
   logic [0:0]  sp_sel_o, lr_sel_o;
   logic        fetch_valid_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   irq_seq u_irq_seq (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .boundary_i(boundary_i),
      .ret_i(ret_i), .pc_i(pc_i), .status_wr_i(status_wr_i),
      .status_wdata_i(status_wdata_i), .sp_wr_i(sp_wr_i), .lr_wr_i(lr_wr_i),
      .reg_wdata_i(reg_wdata_i), .status_o(status_o), .spsr_o(spsr_o),
      .mode_o(mode_o), .sp_sel_o(sp_sel_o), .lr_sel_o(lr_sel_o), .sp_o(sp_o),
      .lr_o(lr_o), .ret_addr_o(ret_addr_o), .fetch_valid_o(fetch_valid_o),
      .fetch_addr_o(fetch_addr_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Inputs are set at a falling edge; one rising edge; back at the falling edge, inputs idle.
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      irq_i = 0; boundary_i = 0; ret_i = 0;
      status_wr_i = 0; sp_wr_i = 0; lr_wr_i = 0;
   endtask

   task automatic wr_status(input logic [31:0] v);
      status_wr_i = 1; status_wdata_i = v; tick();
   endtask

   task automatic wr_regs(input logic [31:0] spv, input logic [31:0] lrv);
      sp_wr_i = 1; reg_wdata_i = spv; tick();
      lr_wr_i = 1; reg_wdata_i = lrv; tick();
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] st, ent, pc, prev;
      @(negedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 status", status_o, 32'h0000_0010);
      chk("R1 spsr", spsr_o, 32'h0);
      chk("R1 fetch", {31'b0, fetch_valid_o}, 32'h0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 sp", sp_o, 32'h0);
      chk("R1 lr", lr_o, 32'h0);

      // R9 empty return after reset
      ret_i = 1; tick();
      chk("R9 status", status_o, 32'h0000_0010);
      chk("R9 fetch", {31'b0, fetch_valid_o}, 32'h0);

      for (int t = 0; t < 2; t++) begin
         for (int k = 0; k < 6; k++) begin
            st  = (32'(k) << 28) | (32'(t) << 5) | 32'h10;
            ent = (st & ~32'h0000_00BF) | 32'h80 | 32'h12;
            pc  = 32'h0800_0100 + 32'(k * 16 + t * 2);
            wr_status(st);
            wr_regs(32'h1000 + 32'(k), 32'h2000 + 32'(k));
            chk("R11 sp bank0", sp_o, 32'h1000 + 32'(k));
            chk("R11 lr bank0", lr_o, 32'h2000 + 32'(k));
            prev = spsr_o;

            // R7: request without a boundary is ignored
            irq_i = 1; boundary_i = 0; pc_i = pc; tick();
            chk("R7 no boundary status", status_o, st);
            chk("R7 no boundary spsr", spsr_o, prev);
            chk("R7 no boundary fetch", {31'b0, fetch_valid_o}, 32'h0);

            // R7: masked request ignored
            wr_status(st | 32'h80);
            irq_i = 1; boundary_i = 1; tick();
            chk("R7 masked status", status_o, st | 32'h80);
            chk("R7 masked spsr", spsr_o, prev);
            wr_status(st);

            // Entry; on k==3 also try a status write that must be dropped (R10)
            irq_i = 1; boundary_i = 1; pc_i = pc;
            if (k == 3) begin status_wr_i = 1; status_wdata_i = 32'hDEAD_BEEF; end
            tick();
            chk("R2 mode", {27'b0, mode_o}, 32'h12);
            chk("R2 sel", {31'b0, sp_sel_o & lr_sel_o}, 32'h1);
            chk("R3 spsr", spsr_o, st);
            chk("R4 status", status_o, ent);
            chk("R5 link", lr_o, pc + (t == 1 ? 32'd6 : 32'd8));
            chk("R6 fetch valid", {31'b0, fetch_valid_o}, 32'h1);
            chk("R6 fetch addr", fetch_addr_o, 32'h18);
            chk("R11 ret addr", ret_addr_o, pc + (t == 1 ? 32'd2 : 32'd4));
            @(negedge clk);
            chk("R6 pulse", {31'b0, fetch_valid_o}, 32'h0);

            // Write IRQ-bank stack pointer
            sp_wr_i = 1; reg_wdata_i = 32'h3000 + 32'(k); tick();
            chk("R11 sp bank1", sp_o, 32'h3000 + 32'(k));

            // R7 nested request while masked
            irq_i = 1; boundary_i = 1; pc_i = 32'hFFFF_0000; tick();
            chk("R7 nested spsr", spsr_o, st);
            chk("R7 nested lr", lr_o, pc + (t == 1 ? 32'd6 : 32'd8));

            if (k == 4) begin
               // R10: unmask inside handler, then return and IRQ together
               wr_status(ent & ~32'h80);
               ret_i = 1; irq_i = 1; boundary_i = 1; tick();
            end else begin
               ret_i = 1;
               if (k == 5) begin status_wr_i = 1; status_wdata_i = 32'h0000_001F; end
               tick();
            end
            chk("R8 status", status_o, st);
            chk("R8 fetch valid", {31'b0, fetch_valid_o}, 32'h1);
            chk("R8 fetch addr", fetch_addr_o, pc + (t == 1 ? 32'd2 : 32'd4));
            chk("R8 sel", {31'b0, sp_sel_o}, 32'h0);
            chk("R2 sp kept", sp_o, 32'h1000 + 32'(k));
            chk("R2 lr kept", lr_o, 32'h2000 + 32'(k));

            // R9 second return has nothing to restore
            ret_i = 1; tick();
            chk("R9 status", status_o, st);
            chk("R9 spsr", spsr_o, st);
            chk("R9 fetch", {31'b0, fetch_valid_o}, 32'h0);
         end
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule